// File: doc/BRIEF.md
# Privileged Status and Stack-Pointer Unit

This unit holds the processor's 16-bit status word. It also holds three stack pointers: one for user code, one for interrupt handling and one master pointer. It has a vector base register as well. The supervisor bit and the master/interrupt bit of the status word together choose which stack pointer is live. The live pointer is presented on a read port and is the only one a stack-pointer write can reach. A command port applies status operations: full-word move, AND, OR, XOR and an exception-return restore. A second group of commands reaches only the five condition flags. A separate interrupt-entry strobe snapshots the status word and then forces supervisor, interrupt-stack mode with a new priority mask.

The unit also forms exception vector addresses. The vector number is scaled by four and added to the vector base. Instruction decode, flag generation and the memory traffic of stacking frames all sit outside the unit. The surrounding core feeds it commands and restore values and consumes its outputs.

Top module: `psr_sp_unit`

## Requirements
- R1: A synchronous active-high reset sets the status word to 0x2700 (supervisor, master bit clear, mask 7). It clears all three stack pointers, the vector base, the saved status word, the vector address and the privilege-violation output.
- R2: Status bits 11, 7, 6 and 5 always read as zero. Writes to them have no effect.
- R3: `sp_sel` reports the live pointer: 0 = user when bit 13 (S) is 0, whatever bit 12 (M) holds; 1 = interrupt pointer when S=1 and M=0; 2 = master pointer when S=1 and M=1. `sp_rd` shows that pointer's value.
- R4: A stack-pointer write updates only the pointer that is live in that cycle. The other two keep their values.
- R5: With S=1, `cmd_op` codes 0..4 act on the writable bits, which are mask 0xF71F. 0 moves `cmd_data` in. 1 ANDs it with the status word. 2 ORs it. 3 XORs it. 4 restores `cmd_data` on exception return. The result is visible one cycle after the command.
- R6: A command with code 0..4 issued while S=0 leaves the status word unchanged. In the next cycle it raises `priv_viol` for exactly one cycle.
- R7: Codes 5, 6 and 7 act in either mode on bits 4:0 only (X,N,Z,V,C). Code 5 moves the low five bits of `cmd_data` in, code 6 ANDs them in and code 7 ORs them in. These codes never raise `priv_viol`.
- R8: On `irq_take`, `saved_sr` captures the status word as it stood before entry, M included. The live word then gets S=1, M=0, T1=T0=0 and mask = `irq_level`, with the flags kept. `irq_take` overrides a command presented in the same cycle.
- R9: The value of M does not block full-word commands. With S=1 and M=1 they take effect without a violation.
- R10: One cycle after sampling, `vec_addr` equals the vector base plus four times `vec_num`. The vector base is loaded through `vbr_wr_en`.
- R11: In a cycle with neither a command nor an interrupt entry, the status word does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Status command strobe |
| cmd_op | input | 3 | Command code (see R5, R7) |
| cmd_data | input | 16 | Operand or restore value |
| irq_take | input | 1 | Interrupt-entry strobe |
| irq_level | input | 3 | New interrupt priority mask on entry |
| sp_wr_en | input | 1 | Write strobe for the live stack pointer |
| sp_wr_data | input | 32 | Stack-pointer write value |
| vbr_wr_en | input | 1 | Vector base write strobe |
| vbr_wr_data | input | 32 | Vector base write value |
| vec_num | input | 8 | Exception vector number |
| sr_out | output | 16 | Live status word |
| saved_sr | output | 16 | Status word captured at interrupt entry |
| priv_viol | output | 1 | One-cycle privilege-violation pulse |
| sp_sel | output | 2 | Live stack pointer identifier |
| sp_rd | output | 32 | Live stack pointer value |
| vec_addr | output | 32 | Computed vector address |

## Verification
On every cycle the assertions check several properties. The reserved bits must read zero. The pointer selection must agree with the S and M bits. User-mode full-word commands must be blocked and followed by a violation pulse. Interrupt entry must save the old word and clear M, and the status word must hold when idle. The vector address must track the base plus the scaled number, and a lone stack write must land on the live pointer.

Some behaviour only the bench scenarios show. These are the exact arithmetic of each command code and the isolation of the two inactive pointers across mode changes. They also include the restriction of flag commands in user mode and the one-cycle length of the violation pulse. The last is that interrupt entry wins over a simultaneous command.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int SR_W      = 16;
  localparam int LEVEL_W   = 3;
  localparam int BIT_T1    = 15;
  localparam int BIT_T0    = 14;
  localparam int BIT_S     = 13;
  localparam int BIT_M     = 12;
  localparam int MASK_LO   = 8;
  localparam logic [SR_W-1:0] SR_WMASK  = 16'hF71F;
  localparam logic [SR_W-1:0] FLAG_MASK = 16'h001F;
  localparam logic [SR_W-1:0] SR_RESET  = 16'h2700;

  typedef enum logic [2:0] {
    OP_SR_MOVE  = 3'd0,
    OP_SR_AND   = 3'd1,
    OP_SR_OR    = 3'd2,
    OP_SR_XOR   = 3'd3,
    OP_SR_RTE   = 3'd4,
    OP_FLG_MOVE = 3'd5,
    OP_FLG_AND  = 3'd6,
    OP_FLG_OR   = 3'd7
  } sr_op_e;

  typedef enum logic [1:0] {
    SEL_USER = 2'd0,
    SEL_ISP  = 2'd1,
    SEL_MSP  = 2'd2
  } sp_sel_e;

  function automatic logic is_full_op(input logic [2:0] op);
    return op <= 3'd4;
  endfunction
endpackage

// File: rtl/psr_status_reg.sv
module psr_status_reg
  import psr_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  input  logic [2:0]         cmd_op,
  input  logic [SR_W-1:0]    cmd_data,
  input  logic               irq_take,
  input  logic [LEVEL_W-1:0] irq_level,
  output logic [SR_W-1:0]    sr_q,
  output logic [SR_W-1:0]    saved_q,
  output logic               viol_q
);
  logic [SR_W-1:0] sr_d;
  logic            viol_d;
  logic [SR_W-1:0] flags_new;
  logic            sup;
  sr_op_e          op;

  assign sup = sr_q[BIT_S];
  assign op  = sr_op_e'(cmd_op);

  always_comb begin
    flags_new = sr_q & FLAG_MASK;
    case (op)
      OP_FLG_MOVE: flags_new = cmd_data & FLAG_MASK;
      OP_FLG_AND:  flags_new = sr_q & cmd_data & FLAG_MASK;
      OP_FLG_OR:   flags_new = (sr_q | cmd_data) & FLAG_MASK;
      default:     flags_new = sr_q & FLAG_MASK;
    endcase
  end

  always_comb begin
    sr_d   = sr_q;
    viol_d = 1'b0;
    if (irq_take) begin
      sr_d                           = sr_q & FLAG_MASK;
      sr_d[BIT_S]                    = 1'b1;
      sr_d[MASK_LO +: LEVEL_W]       = irq_level;
    end else if (cmd_valid) begin
      if (is_full_op(cmd_op) && !sup) begin
        viol_d = 1'b1;
      end else begin
        case (op)
          OP_SR_MOVE: sr_d = cmd_data & SR_WMASK;
          OP_SR_AND:  sr_d = sr_q & cmd_data & SR_WMASK;
          OP_SR_OR:   sr_d = (sr_q | cmd_data) & SR_WMASK;
          OP_SR_XOR:  sr_d = (sr_q ^ cmd_data) & SR_WMASK;
          OP_SR_RTE:  sr_d = cmd_data & SR_WMASK;
          default:    sr_d = (sr_q & ~FLAG_MASK) | flags_new;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q    <= SR_RESET;
      saved_q <= '0;
      viol_q  <= 1'b0;
    end else begin
      sr_q   <= sr_d;
      viol_q <= viol_d;
      if (irq_take) saved_q <= sr_q;
    end
  end
endmodule

// File: rtl/psr_stack_bank.sv
module psr_stack_bank #(
  parameter int ADDR_W = 32,
  parameter int NUM_SP = 3,
  localparam int SEL_W = $clog2(NUM_SP)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  sel,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_data,
  output logic [ADDR_W-1:0] rd_data
);
  logic [ADDR_W-1:0] sp_q [NUM_SP];

  for (genvar i = 0; i < NUM_SP; i++) begin : g_sp
    always_ff @(posedge clk) begin
      if (rst)                                    sp_q[i] <= '0;
      else if (wr_en && (sel == SEL_W'(i)))       sp_q[i] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_SP; i++)
      if (sel == SEL_W'(i)) rd_data = sp_q[i];
  end
endmodule

// File: rtl/psr_vector_calc.sv
module psr_vector_calc #(
  parameter int ADDR_W = 32,
  parameter int VEC_W  = 8,
  localparam int SCALE_SH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vbr_wr_en,
  input  logic [ADDR_W-1:0] vbr_wr_data,
  input  logic [VEC_W-1:0]  vec_num,
  output logic [ADDR_W-1:0] vbr_q,
  output logic [ADDR_W-1:0] vec_addr
);
  logic [ADDR_W-1:0] disp;
  assign disp = ADDR_W'(vec_num) << SCALE_SH;

  always_ff @(posedge clk) begin
    if (rst) begin
      vbr_q    <= '0;
      vec_addr <= '0;
    end else begin
      vec_addr <= vbr_q + disp;
      if (vbr_wr_en) vbr_q <= vbr_wr_data;
    end
  end
endmodule

// File: rtl/psr_sp_unit.sv
module psr_sp_unit
  import psr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [15:0]       cmd_data,
  input  logic              irq_take,
  input  logic [2:0]        irq_level,
  input  logic              sp_wr_en,
  input  logic [ADDR_W-1:0] sp_wr_data,
  input  logic              vbr_wr_en,
  input  logic [ADDR_W-1:0] vbr_wr_data,
  input  logic [VEC_W-1:0]  vec_num,
  output logic [15:0]       sr_out,
  output logic [15:0]       saved_sr,
  output logic              priv_viol,
  output logic [1:0]        sp_sel,
  output logic [ADDR_W-1:0] sp_rd,
  output logic [ADDR_W-1:0] vec_addr
);
  localparam int NUM_SP = 3;

  logic [SR_W-1:0]   sr_q;
  logic [ADDR_W-1:0] vbr_q;
  sp_sel_e           sel;

  psr_status_reg u_status (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_data  (cmd_data),
    .irq_take  (irq_take),
    .irq_level (irq_level),
    .sr_q      (sr_q),
    .saved_q   (saved_sr),
    .viol_q    (priv_viol)
  );

  always_comb begin
    if (!sr_q[BIT_S])     sel = SEL_USER;
    else if (sr_q[BIT_M]) sel = SEL_MSP;
    else                  sel = SEL_ISP;
  end

  psr_stack_bank #(.ADDR_W(ADDR_W), .NUM_SP(NUM_SP)) u_stacks (
    .clk     (clk),
    .rst     (rst),
    .sel     (sel),
    .wr_en   (sp_wr_en),
    .wr_data (sp_wr_data),
    .rd_data (sp_rd)
  );

  psr_vector_calc #(.ADDR_W(ADDR_W), .VEC_W(VEC_W)) u_vector (
    .clk         (clk),
    .rst         (rst),
    .vbr_wr_en   (vbr_wr_en),
    .vbr_wr_data (vbr_wr_data),
    .vec_num     (vec_num),
    .vbr_q       (vbr_q),
    .vec_addr    (vec_addr)
  );

  assign sr_out = sr_q;
  assign sp_sel = sel;
endmodule

// File: rtl/psr_sp_unit_chk.sv
module psr_sp_unit_chk #(
  parameter int ADDR_W = 32,
  parameter int VEC_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic [2:0]        cmd_op,
  input logic              irq_take,
  input logic [2:0]        irq_level,
  input logic              sp_wr_en,
  input logic [ADDR_W-1:0] sp_wr_data,
  input logic [VEC_W-1:0]  vec_num,
  input logic [15:0]       sr_out,
  input logic [15:0]       saved_sr,
  input logic              priv_viol,
  input logic [1:0]        sp_sel,
  input logic [ADDR_W-1:0] sp_rd,
  input logic [ADDR_W-1:0] vec_addr,
  input logic [ADDR_W-1:0] vbr_q
);
  p_rsv_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (sr_out[11] == 1'b0) && (sr_out[7:5] == 3'b000));

  p_sel_r3: assert property (@(posedge clk) disable iff (rst)
    sp_sel == (!sr_out[13] ? 2'd0 : (sr_out[12] ? 2'd2 : 2'd1)));

  p_sp_write_r4: assert property (@(posedge clk) disable iff (rst)
    (sp_wr_en && !cmd_valid && !irq_take) |=> (sp_rd == $past(sp_wr_data)));

  p_user_block_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !irq_take && (cmd_op <= 3'd4) && !sr_out[13])
      |=> ($stable(sr_out) && priv_viol));

  p_viol_cause_r6: assert property (@(posedge clk) disable iff (rst)
    priv_viol |-> ($past(cmd_valid) && !$past(sr_out[13])));

  p_irq_entry_r8: assert property (@(posedge clk) disable iff (rst)
    irq_take |=> (sr_out[13] && !sr_out[12] && (sr_out[15:14] == 2'b00)
                  && (sr_out[10:8] == $past(irq_level))
                  && (saved_sr == $past(sr_out))));

  p_vec_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (vec_addr == $past(vbr_q) + (ADDR_W'($past(vec_num)) << 2)));

  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!cmd_valid && !irq_take) |=> $stable(sr_out));
endmodule

bind psr_sp_unit psr_sp_unit_chk #(.ADDR_W(ADDR_W), .VEC_W(VEC_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_valid  (cmd_valid),
  .cmd_op     (cmd_op),
  .irq_take   (irq_take),
  .irq_level  (irq_level),
  .sp_wr_en   (sp_wr_en),
  .sp_wr_data (sp_wr_data),
  .vec_num    (vec_num),
  .sr_out     (sr_out),
  .saved_sr   (saved_sr),
  .priv_viol  (priv_viol),
  .sp_sel     (sp_sel),
  .sp_rd      (sp_rd),
  .vec_addr   (vec_addr),
  .vbr_q      (vbr_q)
);

// File: tb/psr_sp_unit_test.sv
module psr_sp_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [15:0] cmd_data = 16'h0;
  logic        irq_take = 1'b0;
  logic [2:0]  irq_level = 3'd0;
  logic        sp_wr_en = 1'b0;
  logic [31:0] sp_wr_data = 32'h0;
  logic        vbr_wr_en = 1'b0;
  logic [31:0] vbr_wr_data = 32'h0;
  logic [7:0]  vec_num = 8'h0;
  logic [15:0] sr_out, saved_sr;
  logic        priv_viol;
  logic [1:0]  sp_sel;
  logic [31:0] sp_rd, vec_addr;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  psr_sp_unit uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .irq_take(irq_take), .irq_level(irq_level), .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data),
    .vbr_wr_en(vbr_wr_en), .vbr_wr_data(vbr_wr_data), .vec_num(vec_num),
    .sr_out(sr_out), .saved_sr(saved_sr), .priv_viol(priv_viol), .sp_sel(sp_sel),
    .sp_rd(sp_rd), .vec_addr(vec_addr)
  );

  // behavioural reference model
  logic [15:0] m_sr, m_saved;
  logic        m_viol;
  logic [31:0] m_sp[3];
  logic [31:0] m_vbr, m_vec;

  function automatic int live_idx(input logic [15:0] s);
    if (s[13] == 1'b0) return 0;
    return s[12] ? 2 : 1;
  endfunction

  always @(posedge clk) begin
    logic [15:0] nxt;
    logic        v;
    if (rst) begin
      m_sr = 16'h2700; m_saved = 0; m_viol = 0;
      m_sp[0] = 0; m_sp[1] = 0; m_sp[2] = 0; m_vbr = 0; m_vec = 0;
    end else begin
      nxt = m_sr; v = 0;
      if (sp_wr_en) m_sp[live_idx(m_sr)] = sp_wr_data;
      m_vec = m_vbr + 32'(vec_num) * 4;
      if (vbr_wr_en) m_vbr = vbr_wr_data;
      if (irq_take) begin
        m_saved = m_sr;
        nxt = {2'b00, 1'b1, 1'b0, 1'b0, irq_level, 3'b000, m_sr[4:0]};
      end else if (cmd_valid) begin
        if (cmd_op < 5 && m_sr[13] == 1'b0) v = 1;
        else case (cmd_op)
          0, 4: nxt = cmd_data & 16'hF71F;
          1: nxt = m_sr & cmd_data & 16'hF71F;
          2: nxt = (m_sr | cmd_data) & 16'hF71F;
          3: nxt = (m_sr ^ cmd_data) & 16'hF71F;
          5: nxt = {m_sr[15:5], cmd_data[4:0]};
          6: nxt = {m_sr[15:5], m_sr[4:0] & cmd_data[4:0]};
          default: nxt = {m_sr[15:5], m_sr[4:0] | cmd_data[4:0]};
        endcase
      end
      m_sr = nxt; m_viol = v;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(cur_req, "model sr", 32'(sr_out), 32'(m_sr));
      chk(cur_req, "model saved", 32'(saved_sr), 32'(m_saved));
      chk(cur_req, "model viol", 32'(priv_viol), 32'(m_viol));
      chk(cur_req, "model sp", sp_rd, m_sp[live_idx(m_sr)]);
      chk(cur_req, "model sel", 32'(sp_sel), 32'(live_idx(m_sr)));
      chk(cur_req, "model vec", vec_addr, m_vec);
    end
  end

  task automatic op(input logic [2:0] c, input logic [15:0] d);
    cmd_valid = 1; cmd_op = c; cmd_data = d;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic spw(input logic [31:0] d);
    sp_wr_en = 1; sp_wr_data = d;
    @(negedge clk);
    sp_wr_en = 0;
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    cur_req = "R1";
    chk("R1", "reset sr", 32'(sr_out), 32'h2700);
    chk("R1", "reset sel", 32'(sp_sel), 32'd1);
    chk("R1", "reset sp", sp_rd, 32'h0);
    chk("R1", "reset viol", 32'(priv_viol), 32'h0);
    chk("R1", "reset vec", vec_addr, 32'h0);

    cur_req = "R4"; spw(32'h1000);
    chk("R4", "isp write", sp_rd, 32'h1000);

    cur_req = "R2"; op(3'd0, 16'hFFFF);
    chk("R2", "reserved zero after move", 32'(sr_out), 32'hF71F);
    chk("R3", "msp selected", 32'(sp_sel), 32'd2);
    chk("R3", "msp value", sp_rd, 32'h0);

    cur_req = "R4"; spw(32'h2000);
    chk("R4", "msp write", sp_rd, 32'h2000);
    cur_req = "R5"; op(3'd1, 16'hEFFF);
    chk("R5", "and clears M", 32'(sr_out), 32'hE71F);
    chk("R4", "isp kept", sp_rd, 32'h1000);
    cur_req = "R9"; op(3'd2, 16'h1000);
    chk("R9", "or with M set", 32'(sr_out), 32'hF71F);
    op(3'd3, 16'hC000);
    chk("R9", "xor with M set", 32'(sr_out), 32'h371F);
    chk("R9", "no viol with M", 32'(priv_viol), 32'h0);

    cur_req = "R3"; op(3'd0, 16'h1015);
    chk("R3", "user ignores M", 32'(sp_sel), 32'd0);
    chk("R3", "user sp", sp_rd, 32'h0);
    spw(32'h3000);
    chk("R4", "usp write", sp_rd, 32'h3000);

    cur_req = "R6"; op(3'd1, 16'h0000);
    chk("R6", "and blocked", 32'(sr_out), 32'h1015);
    chk("R6", "viol pulse", 32'(priv_viol), 32'h1);
    @(negedge clk);
    chk("R6", "viol one cycle", 32'(priv_viol), 32'h0);
    op(3'd0, 16'h2700);
    chk("R6", "move blocked", 32'(sr_out), 32'h1015);
    op(3'd4, 16'h2700);
    chk("R6", "rte blocked", 32'(sr_out), 32'h1015);
    chk("R6", "rte viol", 32'(priv_viol), 32'h1);

    cur_req = "R7"; op(3'd5, 16'hFFEA);
    chk("R7", "flag move", 32'(sr_out), 32'h100A);
    chk("R7", "flag no viol", 32'(priv_viol), 32'h0);
    op(3'd6, 16'h0003);
    chk("R7", "flag and", 32'(sr_out), 32'h1002);
    op(3'd7, 16'hFF11);
    chk("R7", "flag or", 32'(sr_out), 32'h1013);

    cur_req = "R8";
    irq_take = 1; irq_level = 3'd5; @(negedge clk); irq_take = 0;
    chk("R8", "entry saved", 32'(saved_sr), 32'h1013);
    chk("R8", "entry sr", 32'(sr_out), 32'h2513);
    chk("R8", "entry isp", sp_rd, 32'h1000);
    op(3'd0, 16'hF700);
    irq_take = 1; irq_level = 3'd3; cmd_valid = 1; cmd_op = 3'd0; cmd_data = 16'h0000;
    @(negedge clk); irq_take = 0; cmd_valid = 0;
    chk("R8", "saved M", 32'(saved_sr), 32'hF700);
    chk("R8", "irq over cmd", 32'(sr_out), 32'h2300);

    cur_req = "R5"; op(3'd4, 16'hB71F);
    chk("R5", "rte restore", 32'(sr_out), 32'hB71F);
    chk("R5", "rte msp", sp_rd, 32'h2000);

    cur_req = "R11"; repeat (3) @(negedge clk);
    chk("R11", "idle hold", 32'(sr_out), 32'hB71F);

    cur_req = "R10";
    vbr_wr_en = 1; vbr_wr_data = 32'h8000; vec_num = 8'h40;
    @(negedge clk); vbr_wr_en = 0;
    @(negedge clk);
    chk("R10", "vec 0x40", vec_addr, 32'h8100);
    vec_num = 8'hFF; @(negedge clk);
    chk("R10", "vec 0xFF", vec_addr, 32'h83FC);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule